// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides, block by block, whether the on-chip flash array may be programmed, erased or verified. Software writes a small register file: a control register that holds a write-enable bit and four operation bits, a pair of erase-enable registers with one bit per erase block, and a RAM-emulation select bit. From these the block drives one enable vector per operation type, each with one bit per erase block.

Three kinds of protection combine. The write-enable bit gates everything. The per-block bits gate erase only. The emulation bit locks out program and erase but leaves verify open. A fault input reports a runaway or an algorithm violation while a program or erase is running. That fault latches a sticky error flag, cuts the running operation off at once and raises a one-clock abort pulse. Afterwards program and erase cannot be entered again, although verify still can. Only a reset clears the flag.

Top module: `flash_guard`

## Requirements
- R1: While control bit 0 (write enable) is 0, every bit of prog_en, erase_en, pv_en and ev_en is 0, whatever the other bits are.
- R2: Address 1 holds the erase enables for blocks 0..7 (bit n selects block n) and address 2 holds those for blocks 8 and up (bit n selects block 8+n). With erase requested (control bit 2), erase_en[b] is 1 only where block b's enable bit is 1. When both registers are zero, no block may be erased.
- R3: The per-block erase enables have no effect on program or verify. A request for program (control bit 1), program-verify (bit 3) or erase-verify (bit 4) drives that operation's enable to 1 in every block.
- R4: While the emulation bit (address 3, bit 0) is 1, prog_en and erase_en are 0 in every block, and pv_en and ev_en still follow their requests.
- R5: A fault_in seen at a clock edge while any program or erase enable is 1 sets the error flag (readable at address 3, bit 7). From the next cycle on, all program and erase enables are 0. A fault_in seen while no program or erase is enabled does nothing.
- R6: Setting the error flag leaves the contents of the control and erase-enable registers unchanged.
- R7: While the error flag is 1, clearing the program or erase bit and then setting it again does not raise prog_en or erase_en.
- R8: While the error flag is 1, writes to the verify bits take effect and pv_en or ev_en follow them.
- R9: The error flag clears only on reset. No register write clears it.
- R10: When more than one of the four operation bits is 1, all four operation enables are 0.
- R11: abort_o is 1 for exactly one cycle: the first cycle in which the error flag reads 1.
- R12: After reset, all registers read 0, the error flag is 0 and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 low block enables, 2 high block enables, 3 emulation) |
| wr_data | input | REG_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | REG_W | Read data for rd_addr; address 3 returns the error flag in bit 7 |
| fault_in | input | 1 | Malfunction or algorithm-violation report |
| prog_en | output | NUM_BLOCKS | Program enable per block |
| erase_en | output | NUM_BLOCKS | Erase enable per block |
| pv_en | output | NUM_BLOCKS | Program-verify enable per block |
| ev_en | output | NUM_BLOCKS | Erase-verify enable per block |
| abort_o | output | 1 | One-cycle pulse when the error flag sets |

## Verification
The bench uses the defaults: twelve erase blocks and 8-bit registers. With these values the high enable register is only partly used. This tests that its bits 4..7 never reach an erase enable while blocks 8..11 follow bits 0..3. The same settings also cover erase masks split across both registers, so the boundary between block 7 and block 8 is checked.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int NUM_BLOCKS = 12,
  parameter int REG_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [1:0]            rd_addr,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  fault_in,
  output logic [NUM_BLOCKS-1:0] prog_en,
  output logic [NUM_BLOCKS-1:0] erase_en,
  output logic [NUM_BLOCKS-1:0] pv_en,
  output logic [NUM_BLOCKS-1:0] ev_en,
  output logic                  abort_o
);
  localparam int BLK_W = 2 * REG_W;

  logic [REG_W-1:0] ctrl_q;
  logic [BLK_W-1:0] blk_q;
  logic             emu_q;
  logic             err_q;
  logic             abort_q;

  logic       wen, req_p, req_e, req_pv, req_ev;
  logic [3:0] ops;
  logic       multi, pe_ok, pe_active;

  assign wen    = ctrl_q[0];
  assign req_p  = ctrl_q[1];
  assign req_e  = ctrl_q[2];
  assign req_pv = ctrl_q[3];
  assign req_ev = ctrl_q[4];
  assign ops    = {req_ev, req_pv, req_e, req_p};
  assign multi  = |(ops & (ops - 4'd1));
  assign pe_ok  = wen & ~multi & ~emu_q & ~err_q;

  assign prog_en  = {NUM_BLOCKS{pe_ok & req_p}};
  assign erase_en = {NUM_BLOCKS{pe_ok & req_e}} & blk_q[NUM_BLOCKS-1:0];
  assign pv_en    = {NUM_BLOCKS{wen & ~multi & req_pv}};
  assign ev_en    = {NUM_BLOCKS{wen & ~multi & req_ev}};
  assign pe_active = (|prog_en) | (|erase_en);
  assign abort_o  = abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      blk_q   <= '0;
      emu_q   <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: ctrl_q <= wr_data;
          2'd1: blk_q[REG_W-1:0] <= wr_data;
          2'd2: blk_q[BLK_W-1:REG_W] <= wr_data;
          default: emu_q <= wr_data[0];
        endcase
      end
      abort_q <= fault_in & pe_active;
      if (fault_in & pe_active) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = ctrl_q;
      2'd1:    rd_data = blk_q[REG_W-1:0];
      2'd2:    rd_data = blk_q[BLK_W-1:REG_W];
      default: begin
        rd_data        = '0;
        rd_data[0]     = emu_q;
        rd_data[REG_W-1] = err_q;
      end
    endcase
  end
endmodule

module flash_guard_chk #(
  parameter int NB = 12,
  parameter int BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wen,
  input logic          emu,
  input logic          err,
  input logic          abort,
  input logic          fault,
  input logic [BW-1:0] blk,
  input logic [NB-1:0] prog_en,
  input logic [NB-1:0] erase_en,
  input logic [NB-1:0] pv_en,
  input logic [NB-1:0] ev_en
);
  logic pe;
  assign pe = (|prog_en) | (|erase_en);

  AST_WEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |-> (prog_en == '0 && erase_en == '0 && pv_en == '0 && ev_en == '0)); // R1
  AST_ERASE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_en & ~blk[NB-1:0]) == '0); // R2
  AST_EMU_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    emu |-> (!pe)); // R4
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && pe) |=> (err && !pe)); // R5
  AST_ERR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !pe); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|prog_en, |erase_en, |pv_en, |ev_en})); // R10
  AST_ABORT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort); // R11
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> err); // R11
endmodule

bind flash_guard flash_guard_chk #(.NB(NUM_BLOCKS), .BW(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wen(wen), .emu(emu_q), .err(err_q),
  .abort(abort_o), .fault(fault_in), .blk(blk_q),
  .prog_en(prog_en), .erase_en(erase_en), .pv_en(pv_en), .ev_en(ev_en)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  localparam int NB = 12;
  localparam int RW = 8;
  localparam int NV = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fault_in = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [RW-1:0] wr_data = '0, rd_data;
  logic [NB-1:0] prog_en, erase_en, pv_en, ev_en;
  logic abort_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard #(.NUM_BLOCKS(NB), .REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fault_in(fault_in),
    .prog_en(prog_en), .erase_en(erase_en), .pv_en(pv_en), .ev_en(ev_en),
    .abort_o(abort_o)
  );

  // {ctrl, low enables, high enables, emulation}
  localparam logic [24:0] VIN [NV] = '{
    {8'h02, 8'hff, 8'hff, 1'b0},  // R1
    {8'h03, 8'h00, 8'h00, 1'b0},  // R3
    {8'h05, 8'h81, 8'h08, 1'b0},  // R2
    {8'h05, 8'h00, 8'h00, 1'b0},  // R2
    {8'h05, 8'hff, 8'hf0, 1'b0},  // R2
    {8'h03, 8'hff, 8'hff, 1'b1},  // R4
    {8'h09, 8'hff, 8'hff, 1'b1},  // R4
    {8'h11, 8'h00, 8'h00, 1'b0},  // R3
    {8'h07, 8'hff, 8'hff, 1'b0},  // R10
    {8'h19, 8'hff, 8'hff, 1'b0},  // R10
    {8'h08, 8'hff, 8'hff, 1'b0}   // R1
  };
  // {prog any, pv any, ev any, erase mask}
  localparam logic [14:0] VEXP [NV] = '{
    {3'b000, 12'h000},
    {3'b100, 12'h000},
    {3'b000, 12'h881},
    {3'b000, 12'h000},
    {3'b000, 12'h0ff},
    {3'b000, 12'h000},
    {3'b010, 12'h000},
    {3'b001, 12'h000},
    {3'b000, 12'h000},
    {3'b000, 12'h000},
    {3'b000, 12'h000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic fault_pulse;
    @(negedge clk);
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
  endtask

  function automatic logic [4*NB-1:0] outs(input logic p, input logic [NB-1:0] e,
                                             input logic pv, input logic ev);
    return {{NB{p}}, e, {NB{pv}}, {NB{ev}}};
  endfunction

  initial begin
    logic [RW-1:0] d;
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R12 reg reset", d, '0);
    end
    chk("R12 enables reset", {prog_en, erase_en, pv_en, ev_en, abort_o}, '0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VIN[i][24:17]);
      wr(2'd1, VIN[i][16:9]);
      wr(2'd2, VIN[i][8:1]);
      wr(2'd3, {7'd0, VIN[i][0]});
      chk($sformatf("vector %0d (R1 R2 R3 R4 R10)", i),
          {prog_en, erase_en, pv_en, ev_en},
          outs(VEXP[i][14], VEXP[i][11:0], VEXP[i][13], VEXP[i][12]));
    end

    // R5: fault with no program/erase active is ignored
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h0f);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    fault_pulse();
    rd(2'd3, d);
    chk("R5 idle fault ignored", {d[7], abort_o}, 2'b00);

    // R5 R11: fault during program
    wr(2'd0, 8'h03);
    chk("R3 program all blocks", prog_en, {NB{1'b1}});
    @(negedge clk);
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
    rd(2'd3, d);
    chk("R5 error set", d[7], 1'b1);
    chk("R5 program aborted", prog_en, '0);
    chk("R11 abort high", abort_o, 1'b1);
    @(negedge clk);
    chk("R11 abort one cycle", abort_o, 1'b0);
    // R6
    rd(2'd0, d);
    chk("R6 ctrl kept", d, 8'h03);
    rd(2'd1, d);
    chk("R6 block enables kept", d, 8'h0f);
    // R7
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    chk("R7 program re-entry blocked", prog_en, '0);
    wr(2'd0, 8'h05);
    chk("R7 erase re-entry blocked", erase_en, '0);
    // R8
    wr(2'd0, 8'h09);
    chk("R8 program verify under error", pv_en, {NB{1'b1}});
    wr(2'd0, 8'h11);
    chk("R8 erase verify under error", ev_en, {NB{1'b1}});
    // R9
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h80);
    rd(2'd3, d);
    chk("R9 error not cleared by write", d[7], 1'b1);
    chk("R11 no abort after", abort_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd3, d);
    chk("R9 reset clears error", d[7], 1'b0);
    // R12 after reset, erase fresh works again
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h05);
    chk("R2 erase after reset", erase_en, 12'h002);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule